// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Flag

This block computes the result of one register-register or register-immediate integer operation per clock. It takes a first operand (the source register value), a second operand (the target register value), a 16-bit immediate, a 5-bit constant shift count and an operation code. It returns the result and a flag that marks a signed-overflow exception. The unit covers addition, bitwise AND and OR, set-on-less-than comparisons, constant and variable shifts, and placing a constant in the upper half of a word. Loads, stores, multiply, divide and register writeback are handled elsewhere.

The block only raises the overflow flag. The pipeline around it decides to drop the register write and take the exception. Inputs are captured on each rising clock edge, and the result and flag appear on registered outputs one cycle later, so every operation has a fixed latency of one cycle.

Top module: `exu_alu`

## Requirements
- R1: While `rst` is high on a rising edge, the next outputs are `res_q` = 0 and `ovf_q` = 0. After that, the outputs show the operation presented on the previous rising edge.
- R2: Codes 0 (signed add) and 2 (signed add immediate) set `ovf_q` exactly when both addends have the same sign bit and the sum's sign bit differs from it. `res_q` still holds the wrapped 32-bit sum.
- R3: Codes 1 (unsigned add) and 3 (unsigned add immediate) return the same 32-bit sum as their signed counterparts and never set `ovf_q`.
- R4: Codes 2, 3, 10 (signed compare immediate) and 11 (unsigned compare immediate) sign-extend `imm` to 32 bits and use it as the second operand.
- R5: Codes 6 (AND immediate) and 7 (OR immediate) zero-extend `imm` to 32 bits.
- R6: Codes 8 and 10 return 1 when `opa` is less than the second operand as a two's-complement number, and 0 otherwise.
- R7: Codes 9 and 11 return 1 when `opa` is less than the second operand as an unsigned number, and 0 otherwise.
- R8: Codes 12 (left logical), 13 (right logical) and 14 (right arithmetic) shift `opb` by `shamt`. The logical shifts fill with zeros. The arithmetic shift fills with `opb[31]`.
- R9: Codes 15 (variable left) and 16 (variable right) shift `opb` with zero fill by `opa[4:0]`. The upper bits of `opa` and the `shamt` input have no effect on the result.
- R10: Code 17 returns `imm` in bits 31:16 and zeros in bits 15:0, whatever `opa` holds.
- R11: Codes 4 and 5 return the bitwise AND and the bitwise OR of `opa` and `opb`.
- R12: Codes 18 to 31 return 0 with `ovf_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code |
| opa | input | 32 | First operand (source register value) |
| opb | input | 32 | Second operand (target register value) |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift count |
| res_q | output | 32 | Registered result |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
The assertions rely on every input holding a defined value on each rising edge, including during reset. Their `$past` terms compare the registered outputs against the operation code and operands sampled one edge earlier, and only after a cycle in which reset was low. The stimulus drives all inputs from time zero and changes them only on falling edges. It presents exactly one operation per cycle, so each expected item in the queue matches the next result.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_ADDI  = 5'd2,
    OP_ADDIU = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_ANDI  = 5'd6,
    OP_ORI   = 5'd7,
    OP_SLT   = 5'd8,
    OP_SLTU  = 5'd9,
    OP_SLTI  = 5'd10,
    OP_SLTIU = 5'd11,
    OP_SLL   = 5'd12,
    OP_SRL   = 5'd13,
    OP_SRA   = 5'd14,
    OP_SLLV  = 5'd15,
    OP_SRLV  = 5'd16,
    OP_LUI   = 5'd17
  } exu_op_e;

  localparam int OP_W = 5;
endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel
  import exu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  exu_op_e         op,
  input  logic [DW-1:0]   opb,
  input  logic [IW-1:0]   imm,
  output logic [DW-1:0]   opnd_b
);
  localparam int EXT_W = DW - IW;

  logic [DW-1:0] imm_sx;
  logic [DW-1:0] imm_zx;

  assign imm_sx = {{EXT_W{imm[IW-1]}}, imm};
  assign imm_zx = {{EXT_W{1'b0}}, imm};

  always_comb begin
    unique case (op)
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: opnd_b = imm_sx;
      OP_ANDI, OP_ORI:                      opnd_b = imm_zx;
      default:                              opnd_b = opb;
    endcase
  end
endmodule

// File: rtl/exu_adder.sv
module exu_adder #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          sgn_ovf,
  output logic          lt_s,
  output logic          lt_u
);
  localparam int MSB = DW - 1;

  assign sum     = a + b;
  assign sgn_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign lt_u    = a < b;
  assign lt_s    = (a[MSB] != b[MSB]) ? a[MSB] : lt_u;
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic [DW-1:0] val,
  input  logic [SW-1:0] amt,
  input  logic          go_left,
  input  logic          arith,
  output logic [DW-1:0] res
);
  logic [DW-1:0] stg [0:SW];
  logic [DW-1:0] val_in;
  logic          fill;

  always_comb begin
    for (int k = 0; k < DW; k++) begin
      val_in[k] = go_left ? val[DW-1-k] : val[k];
    end
  end

  assign fill   = arith & ~go_left & val[DW-1];
  assign stg[0] = val_in;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stg[i+1] = amt[i] ? {{STEP{fill}}, stg[i][DW-1:STEP]} : stg[i];
  end

  always_comb begin
    for (int k = 0; k < DW; k++) begin
      res[k] = go_left ? stg[SW][DW-1-k] : stg[SW][k];
    end
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int SW = $clog2(DW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OP_W-1:0]      op_sel,
  input  logic [DW-1:0]        opa,
  input  logic [DW-1:0]        opb,
  input  logic [IW-1:0]        imm,
  input  logic [SW-1:0]        shamt,
  output logic [DW-1:0]        res_q,
  output logic                 ovf_q
);
  localparam int LOW_W = DW - IW;

  exu_op_e       op;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] sum;
  logic          sgn_ovf;
  logic          lt_s;
  logic          lt_u;
  logic [SW-1:0] sh_amt;
  logic          sh_left;
  logic          sh_arith;
  logic [DW-1:0] sh_res;
  logic [DW-1:0] res_nxt;
  logic          ovf_nxt;

  assign op = exu_op_e'(op_sel);

  exu_operand_sel #(.DW(DW), .IW(IW)) u_opsel (
    .op     (op),
    .opb    (opb),
    .imm    (imm),
    .opnd_b (opnd_b)
  );

  exu_adder #(.DW(DW)) u_add (
    .a       (opa),
    .b       (opnd_b),
    .sum     (sum),
    .sgn_ovf (sgn_ovf),
    .lt_s    (lt_s),
    .lt_u    (lt_u)
  );

  assign sh_amt   = (op == OP_SLLV || op == OP_SRLV) ? opa[SW-1:0] : shamt;
  assign sh_left  = (op == OP_SLL || op == OP_SLLV);
  assign sh_arith = (op == OP_SRA);

  exu_shifter #(.DW(DW), .SW(SW)) u_shf (
    .val     (opb),
    .amt     (sh_amt),
    .go_left (sh_left),
    .arith   (sh_arith),
    .res     (sh_res)
  );

  always_comb begin
    ovf_nxt = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDI: begin
        res_nxt = sum;
        ovf_nxt = sgn_ovf;
      end
      OP_ADDU, OP_ADDIU:        res_nxt = sum;
      OP_AND, OP_ANDI:          res_nxt = opa & opnd_b;
      OP_OR, OP_ORI:            res_nxt = opa | opnd_b;
      OP_SLT, OP_SLTI:          res_nxt = {{(DW-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU:        res_nxt = {{(DW-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV:         res_nxt = sh_res;
      OP_LUI:                   res_nxt = {imm, {LOW_W{1'b0}}};
      default:                  res_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= res_nxt;
      ovf_q <= ovf_nxt;
    end
  end
endmodule

// File: rtl/exu_alu_chk.sv
module exu_alu_chk
  import exu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int SW = $clog2(DW)
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_sel,
  input logic [DW-1:0]     opa,
  input logic [DW-1:0]     opb,
  input logic [IW-1:0]     imm,
  input logic [SW-1:0]     shamt,
  input logic [DW-1:0]     res_q,
  input logic              ovf_q
);
  localparam int LOW_W = DW - IW;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_q == '0 && !ovf_q));

  p_ovf_signed_only_r2: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> ($past(op_sel) == OP_ADD || $past(op_sel) == OP_ADDI));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_sel) == OP_ADDU || $past(op_sel) == OP_ADDIU)) |-> !ovf_q);

  p_addu_sum_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == OP_ADDU) |-> (res_q == $past(opa) + $past(opb)));

  p_cmp_bool_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_sel) >= OP_SLT) && ($past(op_sel) <= OP_SLTIU))
      |-> (res_q[DW-1:1] == '0));

  p_lui_place_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == OP_LUI) |-> (res_q == {$past(imm), {LOW_W{1'b0}}}));

  p_bad_code_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) > OP_LUI) |-> (res_q == '0 && !ovf_q));
endmodule

bind exu_alu exu_alu_chk #(.DW(DW), .IW(IW), .SW(SW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_sel (op_sel),
  .opa    (opa),
  .opb    (opb),
  .imm    (imm),
  .shamt  (shamt),
  .res_q  (res_q),
  .ovf_q  (ovf_q)
);

// File: tb/exu_alu_tb.sv
module exu_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] res_q;
  logic        ovf_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;

  exu_alu dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .imm(imm), .shamt(shamt), .res_q(res_q), .ovf_q(ovf_q)
  );

  task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       input logic [31:0] e_res, input logic e_ovf, input string tag);
    exp_t e;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; imm = im; shamt = sh;
    e.res = e_res; e.ovf = e_ovf; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (res_q !== e.res || ovf_q !== e.ovf) begin
          n_fail++;
          $display("FAIL %s: res=%h ovf=%b expected res=%h ovf=%b",
                   e.tag, res_q, ovf_q, e.res, e.ovf);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    op_sel = 5'd17; opa = 32'hFFFF_FFFF; imm = 16'hABCD;
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (res_q !== 32'h0 || ovf_q !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: res=%h ovf=%b expected res=00000000 ovf=0", res_q, ovf_q);
    end
    @(negedge clk);
    rst = 1'b0;
    op_sel = 5'd1; opa = 32'h0; opb = 32'h0;
    @(posedge clk);
    #2;
    // R2 signed add overflow
    drive(5'd0,  32'h7FFF_FFFF, 32'h1,          16'h0, 5'd0, 32'h8000_0000, 1'b1, "R2 add pos ovf");
    drive(5'd0,  32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0, 32'h0,         1'b1, "R2 add neg ovf");
    drive(5'd0,  32'h5,         32'hFFFF_FFFD, 16'h0, 5'd0, 32'h2,         1'b0, "R2 add mixed sign");
    drive(5'd2,  32'h7FFF_FFFF, 32'h0,         16'h0001, 5'd0, 32'h8000_0000, 1'b1, "R2 addi ovf");
    // R3 unsigned add
    drive(5'd1,  32'h7FFF_FFFF, 32'h1,         16'h0, 5'd0, 32'h8000_0000, 1'b0, "R3 addu no ovf");
    drive(5'd3,  32'h8000_0000, 32'h0,         16'hFFFF, 5'd0, 32'h7FFF_FFFF, 1'b0, "R3 addiu wrap");
    // R4 sign extension
    drive(5'd2,  32'h10,        32'h0,         16'hFFFF, 5'd0, 32'hF,         1'b0, "R4 addi neg imm");
    drive(5'd3,  32'h0,         32'h0,         16'h8000, 5'd0, 32'hFFFF_8000, 1'b0, "R4 addiu sext");
    // R11 and / or
    drive(5'd4,  32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 5'd0, 32'hF000_F000, 1'b0, "R11 and");
    drive(5'd5,  32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 5'd0, 32'hFFF0_FFF0, 1'b0, "R11 or");
    // R5 zero extension
    drive(5'd6,  32'hFFFF_FFFF, 32'h0,         16'h8001, 5'd0, 32'h0000_8001, 1'b0, "R5 andi zext");
    drive(5'd7,  32'h0,         32'h0,         16'hFFFF, 5'd0, 32'h0000_FFFF, 1'b0, "R5 ori zext");
    // R6 / R7 comparisons
    drive(5'd8,  32'hFFFF_FFFF, 32'h1,         16'h0, 5'd0, 32'h1,         1'b0, "R6 slt neg<pos");
    drive(5'd8,  32'h5,         32'h5,         16'h0, 5'd0, 32'h0,         1'b0, "R6 slt equal");
    drive(5'd9,  32'hFFFF_FFFF, 32'h1,         16'h0, 5'd0, 32'h0,         1'b0, "R7 sltu big");
    drive(5'd10, 32'hFFFF_FFFE, 32'h0,         16'hFFFF, 5'd0, 32'h1,     1'b0, "R6 slti -2<-1");
    drive(5'd11, 32'h5,         32'h0,         16'hFFFF, 5'd0, 32'h1,     1'b0, "R7 sltiu sext imm");
    // R8 constant shifts
    drive(5'd12, 32'h0,         32'h1,         16'h0, 5'd31, 32'h8000_0000, 1'b0, "R8 sll 31");
    drive(5'd13, 32'h0,         32'h8000_0000, 16'h0, 5'd4,  32'h0800_0000, 1'b0, "R8 srl zero fill");
    drive(5'd14, 32'h0,         32'h8000_0000, 16'h0, 5'd4,  32'hF800_0000, 1'b0, "R8 sra sign fill");
    drive(5'd14, 32'h0,         32'h4000_0000, 16'h0, 5'd1,  32'h2000_0000, 1'b0, "R8 sra positive");
    // R9 variable shifts
    drive(5'd15, 32'h0000_0024, 32'h1,         16'h0, 5'd7,  32'h10,        1'b0, "R9 sllv low5");
    drive(5'd16, 32'hFFFF_FFE1, 32'h8000_0000, 16'h0, 5'd9,  32'h4000_0000, 1'b0, "R9 srlv low5");
    // R10 upper constant
    drive(5'd17, 32'hFFFF_FFFF, 32'h0,         16'h1234, 5'd0, 32'h1234_0000, 1'b0, "R10 lui");
    // R12 unassigned codes
    drive(5'd31, 32'h7FFF_FFFF, 32'h1,         16'hFFFF, 5'd3, 32'h0,       1'b0, "R12 code 31");
    drive(5'd18, 32'h7FFF_FFFF, 32'h1,         16'hFFFF, 5'd3, 32'h0,       1'b0, "R12 code 18");
    wait (sb_q.size() == 0);
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule